// File: doc/BRIEF.md
# Receiver Error Gate

This block sits between the error detectors of a serial audio receiver and the rest of the chip. Each cycle it takes one strobe per error source: parity, biphase coding, confidence, validity, lock loss and two CRC checks over the control-data blocks. A programmable enable register decides which of these strobes take effect. Only the enabled strobes are passed on.

Enabled errors do four things. They latch into a sticky status register, which clears when it is read. They drive an error pin level during the cycle they occur. They fire a one-cycle interrupt pulse when a source becomes newly active. They can ask the audio datapath to hold or replace the current sample. The two CRC sources count as errors for the pin, the interrupt and the status register. They never request a sample hold. Whether the other sources request a hold is decided by a separate hold configuration input.

Software writes the enable register once it has chosen which errors it cares about. It then polls or services the status register after each interrupt.

Top module: `rx_err_gate`

## Requirements
- R1: The enable register bit positions are: bit 0 parity, bit 1 biphase, bit 2 confidence, bit 3 validity, bit 4 lock loss, bit 5 C-CRC, bit 6 Q-CRC. Bit 7 is not stored. `err_strobe` and `stat_rd_data` use the same bit positions, and `stat_rd_data[7]` always reads 0.
- R2: An error strobe whose enable bit is 1 sets the matching status bit at the next clock edge. The status bit stays set until the status register is read.
- R3: An error strobe whose enable bit is 0 sets no status bit and raises neither `err_pin`, `err_irq` nor `hold_req`.
- R4: `stat_rd_data` shows the status register at all times. A cycle with `stat_rd_en` high clears every status bit at the next edge, unless that bit is set again by R5.
- R5: An enabled strobe in the same cycle as a read keeps its status bit set after the read.
- R6: `err_pin` is high in exactly the cycles in which at least one enabled strobe is high. It is combinational.
- R7: `err_irq` is high in a cycle when some enabled strobe is high that was not enabled-and-high in the previous cycle. A strobe held for several cycles gives a single pulse.
- R8: `hold_req` is high when `hold_cfg` is non-zero and at least one of the enabled parity, biphase, confidence, validity or lock-loss strobes is high.
- R9: The C-CRC and Q-CRC strobes never raise `hold_req`, even when enabled.
- R10: After reset the enable register and the status register are 0, so every strobe is suppressed.
- R11: A write to the enable register takes effect from the cycle after the write. A strobe in the write cycle is gated by the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_strobe | input | 7 | Per-cycle error strobes, bit positions as in R1 |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wr_data | input | 8 | Enable register write data (bit 7 ignored) |
| hold_cfg | input | 2 | Hold configuration; 0 disables sample-hold requests |
| stat_rd_en | input | 1 | Status read strobe; clears the status register |
| stat_rd_data | output | 8 | Current status register contents |
| err_pin | output | 1 | Level: any enabled error this cycle |
| err_irq | output | 1 | One-cycle pulse on a newly active enabled error |
| hold_req | output | 1 | Request to hold or replace the current sample |

## Verification
The bench builds the block with its default seven sources, five of which can request a hold. This keeps both the enable register and the strobe vector at 128 values, so every pairing of enable value and strobe pattern is applied. Bit 7 of the write data is toggled, and `hold_cfg` rotates through all four codes. For each pairing, the pin, interrupt, hold request and latched status are compared with values computed bit by bit. Directed sequences then cover the timing of enable writes, a strobe coinciding with a read, and a strobe held across cycles.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int unsigned REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  // strobes that survive the enable register
  function automatic reg_t gate_hits(reg_t strobes, reg_t enables);
    return strobes & enables;
  endfunction

  // mask with the n lowest bits set
  function automatic reg_t low_ones(int unsigned n);
    reg_t r;
    for (int unsigned i = 0; i < REG_W; i++) r[i] = (i < n);
    return r;
  endfunction

  // sources active now that were not active one cycle ago
  function automatic reg_t fresh_hits(reg_t now_hits, reg_t prev_hits);
    return now_hits & ~prev_hits;
  endfunction

  // sticky update: read wipes old contents, new hits always land
  function automatic reg_t sticky_next(reg_t cur, reg_t hits, logic rd);
    return (rd ? '0 : cur) | hits;
  endfunction
endpackage

// File: rtl/rxe_enable_reg.sv
module rxe_enable_reg
  import rxe_pkg::*;
#(
  parameter int unsigned N_SRC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  reg_t wr_data,
  output reg_t en_o
);
  localparam reg_t KEEP = low_ones(N_SRC);

  reg_t en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wr_data & KEEP;
  end

  assign en_o = en_q;

  // R11: the enable value only moves on a write
  a_r11_enable_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
  // R1: unstored bits stay zero after any write
  a_r1_unused_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_q & ~KEEP) == '0);
endmodule

// File: rtl/rxe_status_reg.sv
module rxe_status_reg
  import rxe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  reg_t hits,
  input  logic rd,
  output reg_t stat_o
);
  reg_t stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= sticky_next(stat_q, hits, rd);
  end

  assign stat_o = stat_q;

  // R2: every enabled hit is recorded
  a_r2_hit_latched: assert property (@(posedge clk) disable iff (!rst_n)
    hits != '0 |=> (stat_q & $past(hits)) == $past(hits));
  // R2: bits persist while nobody reads
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (stat_q & $past(stat_q)) == $past(stat_q));
  // R4: a quiet read empties the register
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hits == '0) |=> stat_q == '0);
  // R5: a coincident hit survives the read
  a_r5_hit_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> stat_q == $past(hits));
endmodule

// File: rtl/rxe_event_out.sv
module rxe_event_out
  import rxe_pkg::*;
#(
  parameter int unsigned N_HOLD = 5,
  parameter int unsigned HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_t              hits,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              pin,
  output logic              irq,
  output logic              hold_req
);
  localparam reg_t HOLD_SET = low_ones(N_HOLD);

  reg_t hits_q;
  reg_t rise;
  reg_t hold_hits;

  always_ff @(posedge clk) begin
    if (!rst_n) hits_q <= '0;
    else        hits_q <= hits;
  end

  assign rise      = fresh_hits(hits, hits_q);
  assign hold_hits = hits & HOLD_SET;
  assign pin       = |hits;
  assign irq       = |rise;
  assign hold_req  = (hold_cfg != '0) && (|hold_hits);

  // R7: an interrupt always coincides with the error level
  a_r7_irq_with_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pin);
  // R7: an unchanged set of hits gives no new pulse
  a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(hits) |-> !irq);
  // R9: CRC-only errors never hold the sample
  a_r9_crc_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((hits & HOLD_SET) == '0) |-> !hold_req);
  // R8: hold disabled by configuration
  a_r8_cfg_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cfg == '0) |-> !hold_req);
endmodule

// File: rtl/rx_err_gate.sv
module rx_err_gate
  import rxe_pkg::*;
#(
  parameter int unsigned N_SRC  = 7,
  parameter int unsigned N_HOLD = 5,
  parameter int unsigned HOLD_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  err_strobe,
  input  logic              en_wr,
  input  logic [REG_W-1:0]  en_wr_data,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic              stat_rd_en,
  output logic [REG_W-1:0]  stat_rd_data,
  output logic              err_pin,
  output logic              err_irq,
  output logic              hold_req
);
  reg_t en_val;
  reg_t strobe_ext;
  reg_t err_hit;
  reg_t stat_val;

  assign strobe_ext = reg_t'(err_strobe);

  rxe_enable_reg #(.N_SRC(N_SRC)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (en_wr),
    .wr_data (en_wr_data),
    .en_o    (en_val)
  );

  assign err_hit = gate_hits(strobe_ext, en_val);

  rxe_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hits   (err_hit),
    .rd     (stat_rd_en),
    .stat_o (stat_val)
  );

  rxe_event_out #(.N_HOLD(N_HOLD), .HOLD_W(HOLD_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits     (err_hit),
    .hold_cfg (hold_cfg),
    .pin      (err_pin),
    .irq      (err_irq),
    .hold_req (hold_req)
  );

  assign stat_rd_data = stat_val;

  // R3: the pin needs an enabled strobe behind it
  a_r3_pin_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    err_pin |-> (strobe_ext & en_val) != '0);
  // R6: an enabled strobe always shows on the pin
  a_r6_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_ext & en_val) != '0) |-> err_pin);
  // R1: top status bit never set
  a_r1_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_data[REG_W-1]);
endmodule

// File: tb/rx_err_gate_test.sv
module rx_err_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] err_strobe = '0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wr_data = '0;
  logic [1:0] hold_cfg = '0;
  logic       stat_rd_en = 1'b0;
  logic [7:0] stat_rd_data;
  logic       err_pin, err_irq, hold_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rx_err_gate uut (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .en_wr(en_wr),
    .en_wr_data(en_wr_data), .hold_cfg(hold_cfg), .stat_rd_en(stat_rd_en),
    .stat_rd_data(stat_rd_data), .err_pin(err_pin), .err_irq(err_irq),
    .hold_req(hold_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, then let combinational outputs settle
  task automatic drive(input logic [6:0] s, input logic wr, input logic [7:0] wd,
                       input logic [1:0] h, input logic rd);
    @(negedge clk);
    err_strobe = s; en_wr = wr; en_wr_data = wd; hold_cfg = h; stat_rd_en = rd;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [6:0] en;
    logic       exp_hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, all strobes suppressed
    drive(7'h7f, 1'b0, 8'h00, 2'd1, 1'b0);
    chk("R10 status after reset", stat_rd_data, 8'h00);
    chk("R10 pin suppressed", err_pin, 1'b0);
    chk("R10 irq suppressed", err_irq, 1'b0);
    chk("R10 hold suppressed", hold_req, 1'b0);
    drive(7'h00, 1'b0, 8'h00, 2'd1, 1'b0);
    chk("R10 no status latched", stat_rd_data, 8'h00);

    // R11: a write gates strobes only from the next cycle
    drive(7'h01, 1'b1, 8'hff, 2'd1, 1'b0);
    chk("R11 old enable in write cycle", err_pin, 1'b0);
    drive(7'h01, 1'b0, 8'h00, 2'd1, 1'b0);
    chk("R11 new enable after write", err_pin, 1'b1);
    chk("R7 first pulse", err_irq, 1'b1);
    // R7: held strobe gives one pulse only
    drive(7'h01, 1'b0, 8'h00, 2'd1, 1'b0);
    chk("R7 held strobe no second pulse", err_irq, 1'b0);
    chk("R6 pin still high", err_pin, 1'b1);
    // R7: an extra source while another is held pulses again
    drive(7'h03, 1'b0, 8'h00, 2'd1, 1'b0);
    chk("R7 new source pulses", err_irq, 1'b1);
    // R5: strobe coincident with read keeps its bit
    drive(7'h04, 1'b0, 8'h00, 2'd0, 1'b1);
    chk("R4 read shows latched bits", stat_rd_data, 8'h03);
    drive(7'h00, 1'b0, 8'h00, 2'd0, 1'b0);
    chk("R5 coincident bit survives read", stat_rd_data, 8'h04);
    drive(7'h00, 1'b0, 8'h00, 2'd0, 1'b1);
    drive(7'h00, 1'b0, 8'h00, 2'd0, 1'b0);
    chk("R4 quiet read clears", stat_rd_data, 8'h00);
    // R9: CRC sources enabled, hold configured
    drive(7'h60, 1'b0, 8'h00, 2'd3, 1'b0);
    chk("R9 crc no hold", hold_req, 1'b0);
    chk("R9 crc still drives pin", err_pin, 1'b1);

    // exhaustive sweep of enable value against strobe pattern
    for (int m = 0; m < 128; m++) begin
      for (int s = 0; s < 128; s++) begin
        logic [1:0] h;
        h = 2'((m + s) % 4);
        // write enable (bit 7 toggled) and clear status
        drive(7'h00, 1'b1, {m[0], 7'(m)}, h, 1'b1);
        drive(7'(s), 1'b0, 8'h00, h, 1'b0);
        en = 7'(s) & 7'(m);
        exp_hold = (h != 2'd0) && ((en & 7'h1f) != 7'h00);
        chk("R6 pin level", err_pin, (en != 7'h00));
        chk("R7 irq pulse", err_irq, (en != 7'h00));
        chk("R8 hold request", hold_req, exp_hold);
        if ((en & 7'h1f) == 7'h00) chk("R9 no hold without sample errors", hold_req, 1'b0);
        if (en == 7'h00 && s != 0) chk("R3 masked strobes silent", {err_pin, err_irq, hold_req}, 3'b000);
        drive(7'h00, 1'b0, 8'h00, h, 1'b1);
        chk("R2 status latched", stat_rd_data, {1'b0, en});
        if (m[0]) chk("R1 bit 7 never set", stat_rd_data[7], 1'b0);
        chk("R7 irq falls", err_irq, 1'b0);
      end
    end
    drive(7'h00, 1'b0, 8'h00, 2'd0, 1'b0);
    chk("R4 status clear after final read", stat_rd_data, 8'h00);
    finish_run();
  end
endmodule